// File: doc/BRIEF.md
# Single-Channel Bus-Mastering Transfer Engine

This block copies a run of words from one region of a shared memory bus to another without the processor doing the work. Software fills in a source start address, a destination start address, a total word count and a block size through a small register port, then sets a go bit. The engine raises a bus request and waits for the processor's grant. Once it holds the bus, it moves each word with a read cycle at the source followed by a write cycle at the destination. Both pointers step by one word after every word.

Two disciplines are available. In the stealing discipline the engine uses only those cycles in which the processor reports that it is not using the bus. In the burst discipline it takes consecutive cycles for a whole block. Under both disciplines the request is dropped for one cycle after every block, so the processor can get the bus back between blocks. When the last word has been written, a sticky done flag is set and an interrupt line follows it if enabled.

Top module: `dma_engine`

## Requirements
- R1: The register port selects a register with `cfg_sel`: 0 source start, 1 destination start, 2 total length in words, 3 block length in words, 4 control (bit 0 go, bit 1 burst discipline, bit 2 interrupt enable), 5 status (bit 0 busy, bit 1 done). Reads are combinational. The go bit reads back as 0.
- R2: Writing control with bit 0 set while idle and with a nonzero length raises `bus_req` in the next cycle. No bus cycle occurs in a cycle where `bus_gnt` is low.
- R3: Word n (counting from 0) is read at source+n and then written to destination+n with the value read. Exactly total-length writes occur.
- R4: In the stealing discipline (control bit 1 = 0), no read or write cycle occurs in a cycle where `cpu_bus_busy` is high.
- R5: In the burst discipline, `cpu_bus_busy` has no effect, and a block of B words occupies 2B consecutive cycles while the grant is held. With a grant that follows the request after one cycle, a transfer of L words in K blocks takes 2L+3K-1 cycles from the go write to done.
- R6: After each block of B words (B = 0 means the whole length is one block), `bus_req` goes low for one cycle and is then raised again. One transfer makes ceil(L/B) requests.
- R7: Status done (bit 1) sets on the clock edge that completes the last write, together with busy (bit 0) falling. It stays set until cleared.
- R8: `irq` equals done AND control bit 2. Writing status with bit 1 set clears done and `irq`.
- R9: A go with total length 0 sets done on that clock edge without ever raising `bus_req`.
- R10: While busy, writes to registers 0 to 4 (including a new go) are ignored.
- R11: After reset all registers read 0, and `bus_req`, `m_re`, `m_we` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_rdata | output | ADDR_W | Register read data for `cfg_sel` |
| bus_req | output | 1 | Request for bus ownership |
| bus_gnt | input | 1 | Grant from the bus owner |
| cpu_bus_busy | input | 1 | Processor is using the bus this cycle |
| m_addr | output | ADDR_W | Bus address |
| m_re | output | 1 | Read cycle |
| m_we | output | 1 | Write cycle |
| m_wdata | output | DATA_W | Write data |
| m_rdata | input | DATA_W | Read data, valid in the read cycle |
| irq | output | 1 | Completion interrupt |

## Verification
A corrupted pointer or holding register shows up on the very next write cycle, as a wrong `m_addr` or `m_wdata`. The bench compares every bus cycle against the address and data it computes for that word. A word or block counter that is off by one shows within one block: the transfer ends early or late, the number of writes differs from the length, the request-rise count differs from ceil(L/B), or the burst run time differs from 2L+3K-1. The length and block size are swept exhaustively over small values, in both disciplines, so every boundary position is covered.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_WRITE,
    ST_GAP
  } dma_state_e;

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_LEN  = 3'd2;
  localparam logic [2:0] SEL_BLK  = 3'd3;
  localparam logic [2:0] SEL_CTRL = 3'd4;
  localparam logic [2:0] SEL_STAT = 3'd5;

  localparam int CTL_GO    = 0;
  localparam int CTL_BURST = 1;
  localparam int CTL_IRQEN = 2;
  localparam int STAT_BUSY = 0;
  localparam int STAT_DONE = 1;

endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    sel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] rdata,
  input  logic          busy,
  input  logic          set_done,
  output logic [AW-1:0] cfg_src,
  output logic [AW-1:0] cfg_dst,
  output logic [LW-1:0] cfg_len,
  output logic [LW-1:0] cfg_blk,
  output logic          cfg_burst,
  output logic          cfg_irq_en,
  output logic          start,
  output logic          done
);

  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic [LW-1:0] len_q, len_d, blk_q, blk_d;
  logic          burst_q, burst_d, ien_q, ien_d, done_q, done_d;
  logic          cfg_open, clr_req;

  // Configuration is writable only while no transfer runs.
  assign cfg_open = wr_en && !busy;
  assign clr_req  = wr_en && (sel == SEL_STAT) && wdata[STAT_DONE];
  assign start    = cfg_open && (sel == SEL_CTRL) && wdata[CTL_GO];

  always_comb begin
    src_d   = src_q;
    dst_d   = dst_q;
    len_d   = len_q;
    blk_d   = blk_q;
    burst_d = burst_q;
    ien_d   = ien_q;
    if (cfg_open) begin
      case (sel)
        SEL_SRC:  src_d = wdata;
        SEL_DST:  dst_d = wdata;
        SEL_LEN:  len_d = wdata[LW-1:0];
        SEL_BLK:  blk_d = wdata[LW-1:0];
        SEL_CTRL: begin
          burst_d = wdata[CTL_BURST];
          ien_d   = wdata[CTL_IRQEN];
        end
        default: ;
      endcase
    end
    // Completion wins over a clear in the same cycle.
    if (set_done)     done_d = 1'b1;
    else if (clr_req) done_d = 1'b0;
    else              done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      len_q   <= '0;
      blk_q   <= '0;
      burst_q <= 1'b0;
      ien_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      src_q   <= src_d;
      dst_q   <= dst_d;
      len_q   <= len_d;
      blk_q   <= blk_d;
      burst_q <= burst_d;
      ien_q   <= ien_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_SRC:  rdata = src_q;
      SEL_DST:  rdata = dst_q;
      SEL_LEN:  rdata[LW-1:0] = len_q;
      SEL_BLK:  rdata[LW-1:0] = blk_q;
      SEL_CTRL: begin
        rdata[CTL_BURST] = burst_q;
        rdata[CTL_IRQEN] = ien_q;
      end
      SEL_STAT: begin
        rdata[STAT_BUSY] = busy;
        rdata[STAT_DONE] = done_q;
      end
      default: rdata = '0;
    endcase
  end

  assign cfg_src    = src_q;
  assign cfg_dst    = dst_q;
  assign cfg_len    = len_q;
  assign cfg_blk    = blk_q;
  assign cfg_burst  = burst_q;
  assign cfg_irq_en = ien_q;
  assign done       = done_q;

  // R7: done holds until software clears it
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !clr_req |=> done_q)
    else $error("done dropped without a clear");

  // R9: zero length completes on the go edge and never becomes busy
  a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    start && (len_q == '0) |=> done_q && !busy)
    else $error("zero-length go did not complete at once");

  // R10: configuration frozen during an active transfer
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(src_q) && $stable(dst_q) && $stable(len_q) &&
             $stable(blk_q) && $stable(burst_q))
    else $error("configuration changed while busy");

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
  import dma_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] len,
  input  logic [LW-1:0] blk,
  input  logic          burst,
  input  logic          gnt,
  input  logic          cpu_busy,
  output logic          bus_req,
  output logic          rd_go,
  output logic          wr_go,
  output logic          load,
  output logic          busy,
  output logic          set_done
);

  localparam logic [LW-1:0] ONE = LW'(1);

  dma_state_e    state_q, state_d;
  logic [LW-1:0] left_q, left_d, blkl_q, blkl_d;
  logic          slot_ok;

  // A bus cycle may be used when granted and, when stealing, when the
  // processor leaves the bus idle.
  assign slot_ok = gnt && (burst || !cpu_busy);

  always_comb begin
    state_d  = state_q;
    left_d   = left_q;
    blkl_d   = blkl_q;
    set_done = 1'b0;
    load     = 1'b0;
    rd_go    = 1'b0;
    wr_go    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (len == '0) begin
            set_done = 1'b1;
          end else begin
            load    = 1'b1;
            left_d  = len;
            blkl_d  = blk;
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (gnt) state_d = ST_READ;
      end
      ST_READ: begin
        if (slot_ok) begin
          rd_go   = 1'b1;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (slot_ok) begin
          wr_go  = 1'b1;
          left_d = left_q - ONE;
          blkl_d = blkl_q - ONE;
          if (left_q == ONE) begin
            set_done = 1'b1;
            state_d  = ST_IDLE;
          end else if ((blk != '0) && (blkl_q == ONE)) begin
            blkl_d  = blk;
            state_d = ST_GAP;
          end else begin
            state_d = ST_READ;
          end
        end
      end
      ST_GAP:  state_d = ST_WAIT;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      blkl_q  <= '0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      blkl_q  <= blkl_d;
    end
  end

  assign bus_req = (state_q == ST_WAIT) || (state_q == ST_READ) ||
                   (state_q == ST_WRITE);
  assign busy    = (state_q != ST_IDLE);

  // R2: no bus cycle without the grant
  a_r2_access_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go || wr_go) |-> gnt && bus_req)
    else $error("bus cycle without grant");

  // R4: stealing uses only idle processor cycles
  a_r4_steal_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go || wr_go) && !burst |-> !cpu_busy)
    else $error("stolen cycle collided with processor");

  // R6: request released for exactly one cycle between blocks
  a_r6_gap_rerequest: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP) |-> !bus_req ##1 bus_req)
    else $error("block gap not one cycle");

  // R3: a read is always followed by a write before the next read
  a_r3_read_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !rd_go)
    else $error("two reads without a write");

endmodule

// File: rtl/dma_datapath.sv
module dma_datapath #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] src_start,
  input  logic [AW-1:0] dst_start,
  input  logic          rd_go,
  input  logic          wr_go,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] m_addr,
  output logic          m_re,
  output logic          m_we,
  output logic [DW-1:0] m_wdata
);

  localparam logic [AW-1:0] STEP = AW'(1);

  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic [DW-1:0] hold_q, hold_d;

  always_comb begin
    src_d  = src_q;
    dst_d  = dst_q;
    hold_d = hold_q;
    if (load) begin
      src_d = src_start;
      dst_d = dst_start;
    end else if (wr_go) begin
      src_d = src_q + STEP;
      dst_d = dst_q + STEP;
    end
    if (rd_go) hold_d = rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      hold_q <= '0;
    end else begin
      src_q  <= src_d;
      dst_q  <= dst_d;
      hold_q <= hold_d;
    end
  end

  assign m_re    = rd_go;
  assign m_we    = wr_go;
  assign m_addr  = wr_go ? dst_q : src_q;
  assign m_wdata = hold_q;

  // R3: the write carries the word captured in the preceding read cycle
  a_r3_write_data: assert property (@(posedge clk) disable iff (!rst_n)
    m_re |=> $stable(src_q))
    else $error("source pointer moved between read and write");

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  input  logic              cpu_bus_busy,
  output logic [ADDR_W-1:0] m_addr,
  output logic              m_re,
  output logic              m_we,
  output logic [DATA_W-1:0] m_wdata,
  input  logic [DATA_W-1:0] m_rdata,
  output logic              irq
);

  logic [ADDR_W-1:0] cfg_src, cfg_dst;
  logic [LEN_W-1:0]  cfg_len, cfg_blk;
  logic              cfg_burst, cfg_irq_en, start, done;
  logic              busy, set_done, load, rd_go, wr_go;

  dma_regfile #(.AW(ADDR_W), .LW(LEN_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_we),
    .sel        (cfg_sel),
    .wdata      (cfg_wdata),
    .rdata      (cfg_rdata),
    .busy       (busy),
    .set_done   (set_done),
    .cfg_src    (cfg_src),
    .cfg_dst    (cfg_dst),
    .cfg_len    (cfg_len),
    .cfg_blk    (cfg_blk),
    .cfg_burst  (cfg_burst),
    .cfg_irq_en (cfg_irq_en),
    .start      (start),
    .done       (done)
  );

  dma_fsm #(.LW(LEN_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .len      (cfg_len),
    .blk      (cfg_blk),
    .burst    (cfg_burst),
    .gnt      (bus_gnt),
    .cpu_busy (cpu_bus_busy),
    .bus_req  (bus_req),
    .rd_go    (rd_go),
    .wr_go    (wr_go),
    .load     (load),
    .busy     (busy),
    .set_done (set_done)
  );

  dma_datapath #(.AW(ADDR_W), .DW(DATA_W)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .src_start (cfg_src),
    .dst_start (cfg_dst),
    .rd_go     (rd_go),
    .wr_go     (wr_go),
    .rdata     (m_rdata),
    .m_addr    (m_addr),
    .m_re      (m_re),
    .m_we      (m_we),
    .m_wdata   (m_wdata)
  );

  assign irq = done && cfg_irq_en;

  // R8: interrupt never without done
  a_r8_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cfg_rdata[STAT_DONE] || (cfg_sel != SEL_STAT))
    else $error("interrupt without done");

  // R7: busy falls exactly when done rises
  a_r7_done_with_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy)
    else $error("done rose while still busy");

endmodule

// File: tb/dma_engine_test.sv
module dma_engine_test;
  import dma_pkg::*;

  logic        clk, rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        bus_req, bus_gnt, cpu_bus_busy;
  logic [15:0] m_addr, m_wdata, m_rdata;
  logic        m_re, m_we, irq;

  int pass_n = 0, total_n = 0;
  int cyc = 0, t0 = 0;
  int req_rise = 0, wr_cnt = 0, rd_cnt = 0, data_err = 0, viol = 0;
  logic gnt_q;
  logic req_prev;
  logic [7:0]  seed;
  logic [15:0] src_base, dst_base;
  int rd_base, wr_base;
  logic mode_burst;

  dma_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .cpu_bus_busy(cpu_bus_busy), .m_addr(m_addr),
    .m_re(m_re), .m_we(m_we), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Bus owner grants one cycle after the request appears.
  assign bus_gnt      = bus_req && gnt_q;
  assign cpu_bus_busy = (cyc % 3) == 1;
  assign m_rdata      = {m_addr[7:0] ^ 8'h5A, seed};

  function automatic logic [15:0] src_word(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, seed};
  endfunction

  always @(posedge clk) begin
    cyc      <= cyc + 1;
    gnt_q    <= rst_n && bus_req;
    req_prev <= bus_req;
    if (bus_req && !req_prev && rst_n) req_rise <= req_rise + 1;
    if (cfg_we && cfg_sel == SEL_CTRL && cfg_wdata[CTL_GO]) t0 <= cyc;
    if ((m_re || m_we) && (!bus_gnt || (!mode_burst && cpu_bus_busy)))
      viol <= viol + 1;
    if (m_re) begin
      rd_cnt <= rd_cnt + 1;
      if (m_addr != src_base + 16'(rd_cnt - rd_base)) data_err <= data_err + 1;
    end
    if (m_we) begin
      wr_cnt <= wr_cnt + 1;
      if (m_addr != dst_base + 16'(wr_cnt - wr_base) ||
          m_wdata != src_word(src_base + 16'(wr_cnt - wr_base)))
        data_err <= data_err + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total_n++;
    if (ok) pass_n++;
    else $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = SEL_STAT;
  endtask

  task automatic rd(input logic [2:0] s, output logic [15:0] v);
    cfg_sel = s;
    #1 v = cfg_rdata;
    cfg_sel = SEL_STAT;
    #1;
  endtask

  task automatic wait_done(output int el);
    logic [15:0] st;
    el = -1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      rd(SEL_STAT, st);
      if (st[STAT_DONE]) begin
        el = cyc - t0 - 1;
        break;
      end
    end
  endtask

  task automatic run(input int L, input int B, input bit burst, input bit ien);
    int nb, el, rise0, viol0, err0;
    logic [15:0] st;
    nb = (L == 0) ? 0 : ((B == 0) ? 1 : (L + B - 1) / B);
    mode_burst = burst;
    seed = 8'(L * 37 + B * 11 + (burst ? 101 : 3));
    src_base = 16'h0100 + 16'(L * 8);
    dst_base = 16'h0800 + 16'(B * 16);
    wr(SEL_SRC, src_base);
    wr(SEL_DST, dst_base);
    wr(SEL_LEN, 16'(L));
    wr(SEL_BLK, 16'(B));
    rise0 = req_rise; viol0 = viol; err0 = data_err;
    rd_base = rd_cnt; wr_base = wr_cnt;
    wr(SEL_CTRL, {13'd0, ien, burst, 1'b1});
    rd(SEL_STAT, st);
    if (L == 0) begin
      check(st[STAT_DONE] && !st[STAT_BUSY] && !bus_req, "R9 zero length done at once",
            int'(st), 2);
      el = 0;
    end else begin
      check(bus_req && st[STAT_BUSY] && !st[STAT_DONE], "R2 request after go",
            int'(bus_req), 1);
      wait_done(el);
      check(el >= 0, "R7 done reached", el, 0);
      rd(SEL_STAT, st);
      check(!st[STAT_BUSY], "R7 busy low with done", int'(st[STAT_BUSY]), 0);
    end
    check(wr_cnt - wr_base == L, "R3 write count", wr_cnt - wr_base, L);
    check(data_err == err0, "R3 addresses and data", data_err - err0, 0);
    check(req_rise - rise0 == nb, "R6 request count", req_rise - rise0, nb);
    check(viol == viol0, "R4 bus cycles only when allowed", viol - viol0, 0);
    if (burst && L > 0)
      check(el == 2 * L + 3 * nb - 1, "R5 burst timing", el, 2 * L + 3 * nb - 1);
    check(irq == ien, "R8 irq follows enable", int'(irq), int'(ien));
    repeat (2) @(negedge clk);
    rd(SEL_STAT, st);
    check(st[STAT_DONE], "R7 done sticky", int'(st[STAT_DONE]), 1);
    wr(SEL_STAT, 16'h0002);
    rd(SEL_STAT, st);
    check(!st[STAT_DONE] && !irq, "R8 clear by status write", int'(st), 0);
  endtask

  initial begin
    logic [15:0] v;
    int el;
    cfg_we = 1'b0; cfg_sel = SEL_STAT; cfg_wdata = '0;
    seed = 8'h00; src_base = '0; dst_base = '0; rd_base = 0; wr_base = 0;
    mode_burst = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), v);
      check(v == 16'd0, "R11 register reset", int'(v), 0);
    end
    check(!bus_req && !m_re && !m_we && !irq, "R11 outputs idle",
          int'({bus_req, m_re, m_we, irq}), 0);

    // R1 readback
    wr(SEL_SRC, 16'h1234);
    wr(SEL_DST, 16'h4321);
    wr(SEL_LEN, 16'h0005);
    wr(SEL_BLK, 16'h0002);
    wr(SEL_CTRL, 16'h0006);
    rd(SEL_SRC, v);  check(v == 16'h1234, "R1 source readback", int'(v), 'h1234);
    rd(SEL_DST, v);  check(v == 16'h4321, "R1 destination readback", int'(v), 'h4321);
    rd(SEL_LEN, v);  check(v == 16'h0005, "R1 length readback", int'(v), 5);
    rd(SEL_BLK, v);  check(v == 16'h0002, "R1 block readback", int'(v), 2);
    rd(SEL_CTRL, v); check(v == 16'h0006, "R1 control readback", int'(v), 6);

    // Sweep both disciplines over small lengths and block sizes
    for (int b = 0; b < 2; b++)
      for (int L = 0; L < 7; L++)
        for (int B = 0; B < 4; B++)
          run(L, B, b[0], 1'((L + B) % 2));

    // R10: writes during a transfer are ignored
    mode_burst = 1'b0;
    seed = 8'hC3; src_base = 16'h0300; dst_base = 16'h0A00;
    wr(SEL_SRC, src_base);
    wr(SEL_DST, dst_base);
    wr(SEL_LEN, 16'd6);
    wr(SEL_BLK, 16'd0);
    rd_base = rd_cnt; wr_base = wr_cnt;
    wr(SEL_CTRL, 16'h0001);
    wr(SEL_SRC, 16'h0077);
    wr(SEL_LEN, 16'd1);
    wr(SEL_CTRL, 16'h0003);
    wait_done(el);
    check(el >= 0, "R10 transfer completes", el, 0);
    check(wr_cnt - wr_base == 6, "R10 length kept", wr_cnt - wr_base, 6);
    rd(SEL_SRC, v);  check(v == 16'h0300, "R10 source kept", int'(v), 'h300);
    rd(SEL_LEN, v);  check(v == 16'd6, "R10 length register kept", int'(v), 6);
    rd(SEL_CTRL, v); check(v == 16'd0, "R10 control kept", int'(v), 0);
    wr(SEL_STAT, 16'h0002);

    $display("%0d/%0d checks passed", pass_n, total_n);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    total_n++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", pass_n, total_n);
    $finish;
  end

endmodule